// File: doc/BRIEF.md
# Instruction-Cache Tag Array with Direct Software Window

This block holds the tag store of a two-way set-associative instruction cache, 256 entries per way, and gives privileged software a direct path into that store through a 16 MB memory-mapped window. Software issues longword loads and stores on a simple slave port. The address chooses a way and an entry outright. A load returns the stored tag and valid bit packed into a 32-bit word. A store writes a new tag and valid bit into the chosen slot. No tag comparison takes place on either path.

The fetch path has its own lookup port. It presents an entry index and, one clock later, receives the tags and valid bits of both ways at that entry. Writes that use the association mode are not supported here. They are acknowledged with an error and leave the array unchanged. Misaligned accesses, sub-word accesses and accesses outside the window are rejected the same way.

The slave port runs a two-state machine. In `ST_IDLE` the port is ready. Accepting a request (the transition IDLE→RESP) performs the array write or captures the read data. In `ST_RESP` the response and any error are presented for exactly one cycle. The machine then returns unconditionally (RESP→IDLE).

Top module: `itag_window`

## Requirements
- R1: A request is decoded as a window access only when address bits [31:24] equal 0xF0. Any other address gives an error response, leaves the array unchanged and reads as zero.
- R2: Address bit [13] selects the way (0 or 1), and address bits [12:5] select the entry (0 to 255).
- R3: A successful read returns the stored 19-bit tag in data bits [28:10] and the valid bit in data bit [0]. Bits [31:29] and [9:1] read as zero.
- R4: A successful write (address bit [3] = 0) stores write-data bits [28:10] as the tag and bit [0] as the valid bit. Write-data bits [31:29] and [9:1] are discarded.
- R5: A read ignores address bit [3] and returns the same indexed contents whether that bit is 0 or 1.
- R6: A write with address bit [3] = 1 is acknowledged with the error flag set and does not modify the array.
- R7: An access whose size code is not 2'b10 (longword), or whose address bits [1:0] are nonzero, is rejected with the error flag. It does not modify the array and reads as zero.
- R8: `sw_req_ready` is high in `ST_IDLE`. `sw_rsp_valid` is high exactly in the cycle after a request is accepted, and `sw_req_ready` is low during that cycle.
- R9: Reset clears every valid bit in both ways.
- R10: A lookup request returns, in the next cycle, the tag and valid bit of both ways at `lk_index`, with `lk_rsp_valid` high for that cycle.
- R11: When a lookup and a software write target the same entry in the same cycle, the write is applied, and the lookup returns the contents from before the write.
- R12: `sw_err` is high only in a cycle where `sw_rsp_valid` is high, and only for that one cycle per rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req_valid | input | 1 | Software request present |
| sw_req_ready | output | 1 | Port can accept a request |
| sw_we | input | 1 | 1 = store, 0 = load |
| sw_size | input | 2 | Access size code (2'b10 = longword) |
| sw_addr | input | 32 | Byte address |
| sw_wdata | input | 32 | Store data |
| sw_rsp_valid | output | 1 | Response cycle |
| sw_rsp_rdata | output | 32 | Load data (zero on error or store) |
| sw_err | output | 1 | Request rejected (one-cycle pulse with the response) |
| lk_req | input | 1 | Fetch-path lookup request |
| lk_index | input | 8 | Entry to look up |
| lk_rsp_valid | output | 1 | Lookup result present |
| lk_tag0 | output | 19 | Way 0 tag at the entry |
| lk_tag1 | output | 19 | Way 1 tag at the entry |
| lk_vld | output | 2 | Valid bits, bit n for way n |

## Verification
The hardest case to reach from the ports is a lookup and a software store that hit the same entry on the same clock edge. The bench must line up the fetch-side request with the slave-port accept to the exact cycle. It does this by driving both on the same falling edge. It then checks that the lookup result carries the old tag and valid bit while a later software read shows the new ones. A second hard case is showing that reset clears the valid bits. For this the bench fills entries in both ways, applies a mid-run reset, and reads the entries back through both ports.

// File: rtl/itw_pkg.sv
package itw_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } itw_state_e;

    localparam logic [1:0] SZ_LONG   = 2'b10;
    localparam int         WAY_BIT   = 13;
    localparam int         IDX_LSB   = 5;
    localparam int         ASSOC_BIT = 3;
    localparam int         TAG_LSB   = 10;
endpackage

// File: rtl/itw_decode.sv
module itw_decode
    import itw_pkg::*;
#(
    parameter int          IDX_W   = 8,
    parameter int          TAG_W   = 19,
    parameter logic [7:0]  WIN_SEL = 8'hF0
) (
    input  logic [31:0]      addr,
    input  logic [31:0]      wdata,
    input  logic [1:0]       size,
    input  logic             we,
    output logic             way,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag,
    output logic             vbit,
    output logic             reject
);
    logic in_window;
    logic aligned;
    logic assoc;

    assign in_window = (addr[31:24] == WIN_SEL);
    assign aligned   = (addr[1:0] == 2'b00) && (size == SZ_LONG);
    assign assoc     = addr[ASSOC_BIT];

    assign way  = addr[WAY_BIT];
    assign idx  = addr[IDX_LSB +: IDX_W];
    assign tag  = wdata[TAG_LSB +: TAG_W];
    assign vbit = wdata[0];

    always_comb begin
        reject = 1'b0;
        if (!in_window || !aligned) reject = 1'b1;
        if (we && assoc)            reject = 1'b1;
    end

    logic unused_dec;
    assign unused_dec = ^{addr[23:14], addr[4], addr[2], wdata[31:29], wdata[9:1]};
endmodule

// File: rtl/itw_tag_ram.sv
module itw_tag_ram #(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 19,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int WAYS   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_way,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_v,
    input  logic             rd_en,
    input  logic             rd_way,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_v,
    input  logic             lk_en,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_rsp,
    output logic [WAYS-1:0][TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  lk_v
);
    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic [WAYS-1:0]            way_v;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tags [ENTRIES];
        logic [ENTRIES-1:0] vals;
        logic hit_wr;

        assign hit_wr = wr_en && (wr_way == w[0]);

        always_ff @(posedge clk) begin
            if (hit_wr) tags[wr_idx] <= wr_tag;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)       vals <= '0;
            else if (hit_wr)  vals[wr_idx] <= wr_v;
        end

        always_ff @(posedge clk) begin
            if (lk_en) begin
                lk_tag[w] <= tags[lk_idx];
                lk_v[w]   <= vals[lk_idx] && rst_n;
            end
        end

        assign way_tag[w] = tags[rd_idx];
        assign way_v[w]   = vals[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lk_rsp <= 1'b0;
        else        lk_rsp <= lk_en;
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_tag <= way_tag[rd_way];
            rd_v   <= way_v[rd_way];
        end
    end
endmodule

// File: rtl/itw_ctrl.sv
module itw_ctrl
    import itw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_we,
    input  logic reject,
    output logic req_ready,
    output logic accept,
    output logic do_write,
    output logic do_read,
    output logic rsp_valid,
    output logic rsp_err,
    output logic rsp_rd_ok
);
    itw_state_e state_q, state_d;
    logic err_q;
    logic rd_ok_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
            rd_ok_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                err_q   <= reject;
                rd_ok_q <= !req_we && !reject;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
        accept    = req_ready && req_valid;
        do_write  = accept && req_we && !reject;
        do_read   = accept && !req_we && !reject;
        rsp_err   = rsp_valid && err_q;
        rsp_rd_ok = rsp_valid && rd_ok_q;
    end
endmodule

// File: rtl/itag_window.sv
module itag_window
    import itw_pkg::*;
#(
    parameter int         ENTRIES = 256,
    parameter int         TAG_W   = 19,
    parameter logic [7:0] WIN_SEL = 8'hF0,
    localparam int        IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req_valid,
    output logic             sw_req_ready,
    input  logic             sw_we,
    input  logic [1:0]       sw_size,
    input  logic [31:0]      sw_addr,
    input  logic [31:0]      sw_wdata,
    output logic             sw_rsp_valid,
    output logic [31:0]      sw_rsp_rdata,
    output logic             sw_err,
    input  logic             lk_req,
    input  logic [IDX_W-1:0] lk_index,
    output logic             lk_rsp_valid,
    output logic [TAG_W-1:0] lk_tag0,
    output logic [TAG_W-1:0] lk_tag1,
    output logic [1:0]       lk_vld
);
    localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

    logic             d_way;
    logic [IDX_W-1:0] d_idx;
    logic [TAG_W-1:0] d_tag;
    logic             d_v;
    logic             d_reject;
    logic             accept;
    logic             do_write;
    logic             do_read;
    logic             rd_ok;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_v;
    logic [1:0][TAG_W-1:0] lk_tag_w;

    itw_decode #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WIN_SEL(WIN_SEL)) u_dec (
        .addr   (sw_addr),
        .wdata  (sw_wdata),
        .size   (sw_size),
        .we     (sw_we),
        .way    (d_way),
        .idx    (d_idx),
        .tag    (d_tag),
        .vbit   (d_v),
        .reject (d_reject)
    );

    itw_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (sw_req_valid),
        .req_we    (sw_we),
        .reject    (d_reject),
        .req_ready (sw_req_ready),
        .accept    (accept),
        .do_write  (do_write),
        .do_read   (do_read),
        .rsp_valid (sw_rsp_valid),
        .rsp_err   (sw_err),
        .rsp_rd_ok (rd_ok)
    );

    itw_tag_ram #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (do_write),
        .wr_way (d_way),
        .wr_idx (d_idx),
        .wr_tag (d_tag),
        .wr_v   (d_v),
        .rd_en  (do_read),
        .rd_way (d_way),
        .rd_idx (d_idx),
        .rd_tag (rd_tag),
        .rd_v   (rd_v),
        .lk_en  (lk_req),
        .lk_idx (lk_index),
        .lk_rsp (lk_rsp_valid),
        .lk_tag (lk_tag_w),
        .lk_v   (lk_vld)
    );

    assign lk_tag0 = lk_tag_w[0];
    assign lk_tag1 = lk_tag_w[1];

    always_comb begin
        sw_rsp_rdata = '0;
        if (rd_ok) begin
            sw_rsp_rdata[TAG_MSB:TAG_LSB] = rd_tag;
            sw_rsp_rdata[0]               = rd_v;
        end
    end
    logic unused_acc;
    assign unused_acc = accept;
endmodule

// File: rtl/itag_window_chk.sv
module itag_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_req_valid,
    input logic        sw_req_ready,
    input logic        sw_rsp_valid,
    input logic [31:0] sw_rsp_rdata,
    input logic        sw_err,
    input logic        lk_req,
    input logic        lk_rsp_valid
);
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req_valid && sw_req_ready) |=> sw_rsp_valid) else $error("rsp missing"); // R8
    AST_NOT_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rsp_valid |-> !sw_req_ready) else $error("ready during rsp"); // R8
    AST_ERR_ONLY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        sw_err |-> sw_rsp_valid) else $error("stray err"); // R12
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_err |=> !sw_err) else $error("err held"); // R12
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rsp_valid |-> (sw_rsp_rdata[31:29] == 3'b0 && sw_rsp_rdata[9:1] == 9'b0)) else $error("reserved bits"); // R3
    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sw_err |-> (sw_rsp_rdata == 32'b0)) else $error("err data"); // R7
    AST_LOOKUP_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_rsp_valid) else $error("lookup rsp"); // R10
endmodule

bind itag_window itag_window_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_req_valid (sw_req_valid),
    .sw_req_ready (sw_req_ready),
    .sw_rsp_valid (sw_rsp_valid),
    .sw_rsp_rdata (sw_rsp_rdata),
    .sw_err       (sw_err),
    .lk_req       (lk_req),
    .lk_rsp_valid (lk_rsp_valid)
);

// File: tb/itag_window_bench.sv
module itag_window_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_req_valid = 1'b0;
    logic        sw_req_ready;
    logic        sw_we = 1'b0;
    logic [1:0]  sw_size = 2'b10;
    logic [31:0] sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic        sw_rsp_valid;
    logic [31:0] sw_rsp_rdata;
    logic        sw_err;
    logic        lk_req = 1'b0;
    logic [7:0]  lk_index = '0;
    logic        lk_rsp_valid;
    logic [18:0] lk_tag0, lk_tag1;
    logic [1:0]  lk_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    itag_window u_itag_window (.*);

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    typedef struct { logic [31:0] data; logic err; string req; } exp_t;
    exp_t sbq[$];

    logic [18:0] mtag [2][256];
    logic        mval [2][256];

    function automatic logic [31:0] mk_addr(input bit way, input int idx, input bit a);
        return {8'hF0, 10'h155, way, idx[7:0], 1'b0, a, 3'b000};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic [1:0] sz, input string req);
        exp_t e;
        bit ok;
        bit way;
        int idx;
        way = addr[13];
        idx = int'(addr[12:5]);
        ok  = (addr[31:24] == 8'hF0) && (addr[1:0] == 0) && (sz == 2'b10) && !(we && addr[3]);
        e.req = req;
        e.err = !ok;
        e.data = '0;
        if (ok && !we) e.data = {3'b0, mtag[way][idx], 9'b0, mval[way][idx]};
        sbq.push_back(e);
        @(negedge clk);
        chk({req, "/R8 ready"}, 64'(sw_req_ready), 64'd1);
        sw_req_valid = 1; sw_we = we; sw_addr = addr; sw_wdata = wd; sw_size = sz;
        @(negedge clk);
        chk({req, "/R8 busy"}, 64'(sw_req_ready), 64'd0);
        sw_req_valid = 0; sw_we = 0; sw_size = 2'b10;
        if (ok && we) begin
            mtag[way][idx] = wd[28:10];
            mval[way][idx] = wd[0];
        end
    endtask

    task automatic rd(input bit way, input int idx, input bit a, input string req);
        access(0, mk_addr(way, idx, a), 32'h0, 2'b10, req);
    endtask

    task automatic wr(input bit way, input int idx, input logic [31:0] wd, input string req);
        access(1, mk_addr(way, idx, 1'b0), wd, 2'b10, req);
    endtask

    // monitor: pops expected items when responses appear
    always @(negedge clk) begin
        if (rst_n && sw_rsp_valid) begin
            if (sbq.size() == 0) begin
                chk("R8 unexpected rsp", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({e.req, " data"}, 64'(sw_rsp_rdata), 64'(e.data));
                chk({e.req, " err"}, 64'(sw_err), 64'(e.err));
            end
        end else if (rst_n && sw_err) begin
            chk("R12 err without rsp", 64'd1, 64'd0);
        end
    end

    task automatic lookup(input int idx, input string req);
        logic [63:0] exp;
        exp = {2'b0, mtag[0][idx], mtag[1][idx], 22'b0, mval[1][idx], mval[0][idx]};
        @(negedge clk);
        lk_req = 1; lk_index = idx[7:0];
        @(negedge clk);
        lk_req = 0;
        chk({req, " lkvalid"}, 64'(lk_rsp_valid), 64'd1);
        chk(req, {2'b0, lk_tag0, lk_tag1, 22'b0, lk_vld}, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 256; i++) mval[w][i] = 0;
    endtask

    initial begin
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 256; i++) begin mtag[w][i] = 'x; mval[w][i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8 reset rsp_valid", 64'(sw_rsp_valid), 64'd0);
        chk("R12 reset err", 64'(sw_err), 64'd0);
        // seed tags so reads compare defined values
        for (int i = 0; i < 8; i++) begin
            wr(0, i * 37, {3'b111, 19'(i * 4099 + 1), 9'h1FF, 1'b0}, "R4 seed w0");
            wr(1, i * 37, {3'b000, 19'(i * 777 + 5), 9'h000, 1'b1}, "R4 seed w1");
        end
        for (int i = 0; i < 8; i++) begin
            rd(0, i * 37, 0, "R3 R2 read w0");
            rd(1, i * 37, 0, "R3 R2 read w1");
        end
        wr(1, 255, 32'hFFFF_FFFF, "R4 all-ones");
        wr(0, 255, 32'h0000_0000, "R4 zeros");
        rd(1, 255, 0, "R3 edge entry way1");
        rd(0, 255, 1, "R5 assoc bit on read");
        rd(1, 255, 1, "R5 assoc bit on read w1");
        // R6: associative write rejected, array untouched
        access(1, mk_addr(1, 255, 1'b1), 32'h1234_5400, 2'b10, "R6 assoc write");
        rd(1, 255, 0, "R6 unchanged");
        // R7: misaligned and sub-word
        access(1, mk_addr(0, 74, 0) | 32'h2, 32'h0000_0C01, 2'b10, "R7 misaligned wr");
        access(1, mk_addr(0, 74, 0), 32'h0000_0C01, 2'b01, "R7 halfword wr");
        access(0, mk_addr(0, 74, 0) | 32'h1, 32'h0, 2'b10, "R7 misaligned rd");
        access(0, mk_addr(0, 74, 0), 32'h0, 2'b00, "R7 byte rd");
        rd(0, 74, 0, "R7 unchanged");
        // R1: outside window
        access(1, 32'hF100_0000 | mk_addr(0, 74, 0) & 32'h00FF_FFFF, 32'h0000_FC01, 2'b10, "R1 outside wr");
        access(0, 32'hE000_0940, 32'h0, 2'b10, "R1 outside rd");
        rd(0, 74, 0, "R1 unchanged");
        // R10 lookups
        lookup(0, "R10 lookup 0");
        lookup(255, "R10 lookup 255");
        lookup(111, "R10 lookup 111");
        // R11: same-cycle lookup and write to same entry
        begin
            logic [63:0] exp;
            exp = {2'b0, mtag[0][111], mtag[1][111], 22'b0, mval[1][111], mval[0][111]};
            sbq.push_back('{data: 32'h0, err: 1'b0, req: "R11 write"});
            @(negedge clk);
            sw_req_valid = 1; sw_we = 1; sw_addr = mk_addr(0, 111, 0);
            sw_wdata = {3'b0, 19'h5A5A5, 9'b0, 1'b1};
            lk_req = 1; lk_index = 8'd111;
            @(negedge clk);
            sw_req_valid = 0; sw_we = 0; lk_req = 0;
            chk("R11 lookup old", {2'b0, lk_tag0, lk_tag1, 22'b0, lk_vld}, exp);
            mtag[0][111] = 19'h5A5A5; mval[0][111] = 1;
        end
        rd(0, 111, 0, "R11 write applied");
        lookup(111, "R11 lookup new");
        // R9: reset clears valids
        do_reset();
        @(negedge clk);
        chk("R9 reset ready", 64'(sw_req_ready), 64'd1);
        lookup(111, "R9 lookup after reset");
        lookup(255, "R9 lookup after reset 255");
        rd(1, 37, 0, "R9 read after reset");
        rd(0, 111, 0, "R9 read after reset w0");
        repeat (3) @(negedge clk);
        chk("R8 queue drained", 64'(sbq.size()), 64'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule